// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between the serial protocol engine of a two-wire memory device and its nonvolatile array. While a write transaction is open it gathers the data bytes into a page latch of `PAGE_BYTES` entries. The word address that opens the transaction chooses the page through its upper bits and the first in-page offset through its low bits. Each accepted byte lands at the current offset. The offset then steps forward and wraps inside the page, so a master that sends more than a page of data overwrites the bytes it sent earlier.

Nothing reaches the array until the stop condition that closes the transaction. At that stop, if at least one byte was accepted and write protection did not block the transaction, the block raises `busy` for exactly `WR_CYCLES` clocks. This stands in for the programming time. During that window it issues one array write for each page offset that actually received data, and then it pulses `done`. The protocol engine uses `busy` to withhold acknowledges while the cycle runs.

A repeated start before the stop throws the gathered bytes away. A data byte that arrives while the inhibit input is high blocks the whole transaction. Every strobe that arrives while `busy` is high is ignored.

Top module: `page_write_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `busy`, `done` and `arr_we` are all 0.
- R2: A `wr_addr_stb` pulse opens a transaction. Bits `[ADDR_W-1:OFS_W]` of `wr_addr` select the page, and bits `[OFS_W-1:0]` (the low 4 bits by default) give the starting offset. Each `byte_stb` with `wr_inhibit` low stores `byte_data` at the current offset and then adds one to the offset.
- R3: The offset after `PAGE_BYTES-1` is 0 within the same page. A byte stored at an offset that already holds data replaces it, and only the last value is written.
- R4: A `stop_stb` that closes a transaction holding at least one stored byte sets `busy` on the following clock. `busy` then stays high for exactly `WR_CYCLES` cycles. `done` is high for one cycle, in the first cycle after `busy` falls.
- R5: In busy cycle k, counted from 0, the block asserts `arr_we` if and only if k < `PAGE_BYTES` and offset k received data. It drives `arr_addr = {page, k}` and `arr_wdata` with the stored byte. Writes therefore come out in ascending offset order, whatever the starting offset was.
- R6: No array write happens before the stop. A stop that closes a transaction with no stored bytes starts no cycle.
- R7: A `byte_stb` with `wr_inhibit` high blocks the transaction. That byte and every later one are dropped, and the closing stop starts no cycle and produces no writes.
- R8: A `start_stb` before the stop discards every stored byte. A stop that follows without new data starts no cycle. After a new address, only the new bytes are written.
- R9: While `busy` is high, address, byte, start and stop strobes have no effect. They neither extend the cycle nor change what is written.
- R10: When a cycle ends, all stored bytes are cleared. A later transaction writes only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_addr_stb | input | 1 | Word address received: opens a transaction |
| wr_addr | input | ADDR_W | Word address (page and starting offset) |
| byte_stb | input | 1 | One data byte received |
| byte_data | input | DATA_W | Received data byte |
| stop_stb | input | 1 | Stop condition seen |
| start_stb | input | 1 | Repeated start condition seen |
| wr_inhibit | input | 1 | Write protection or abort: blocks the transaction |
| arr_we | output | 1 | Array write request |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle pulse at the end of the write cycle |

## Verification
The assertions check several properties on every cycle: array writes happen only inside the commit window, `busy` lasts exactly the configured count and `done` follows it by one cycle, and the latch holds no data while the transaction is blocked, after a repeated start, or once the cycle is done. They also check that the latch stays frozen while the cycle runs. Other behaviour shows up only in the bench's scenarios, which compare each write against a queue of expected writes. These include the actual address and data values, last-write-wins after the offset wraps, the exact busy cycle in which each offset is written, and the absence of any effect from strobes sent during a cycle.

// File: rtl/pws_pkg.sv
// Package for the page write sequencer: shared transaction state encoding.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pws_pkg;

    // Transaction phase of the page write sequencer.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,  // no write transaction open
        PH_COLLECT = 2'd1,  // address received, gathering data bytes
        PH_BLOCKED = 2'd2,  // protection hit, waiting for stop or start
        PH_COMMIT  = 2'd3   // write cycle running
    } phase_t;

endpackage

// File: rtl/pws_page_latch.sv
// Page latch: one data register and one valid bit per in-page offset, plus
// the page number and the wrapping offset pointer.
// Assumes PAGE_BYTES is a power of two. Priority is clear, then load, then write.
module pws_page_latch #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFS_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         load,
    input  logic [ADDR_W-1:0]            load_addr,
    input  logic                         wr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [PAGE_W-1:0]            page,
    output logic [PAGE_BYTES-1:0]        valid,
    output logic [PAGE_BYTES*DATA_W-1:0] data_flat,
    output logic                         any_valid
);

    logic [OFS_W-1:0]  ptr;
    logic [DATA_W-1:0] mem [PAGE_BYTES];

    // Page number and offset pointer: loaded from the word address, stepped per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            ptr  <= '0;
        end else if (load) begin
            page <= load_addr[ADDR_W-1:OFS_W];
            ptr  <= load_addr[OFS_W-1:0];
        end else if (wr && !clear) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Valid bits and data registers: set on a write, cleared on clear or a new load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) mem[i] <= '0;
        end else if (clear || load) begin
            valid <= '0;
        end else if (wr) begin
            valid[ptr] <= 1'b1;
            mem[ptr]   <= wdata;
        end
    end

    // Flatten the per-offset registers for the commit scanner.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign data_flat[g*DATA_W +: DATA_W] = mem[g];
    end

    // Summary flag: at least one offset holds received data.
    assign any_valid = |valid;

    // R2/R3: an accepted byte marks the offset that the pointer held.
    a_r3_write_marks_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clear && !load) |=> valid[$past(ptr)]);

endmodule

// File: rtl/pws_cycle_timer.sv
// Write cycle timer: once started, it holds busy for exactly WR_CYCLES clocks,
// exposes the running cycle index, and pulses done as busy falls.
// Assumes WR_CYCLES >= 2. A start while busy is ignored.
module pws_cycle_timer #(
    parameter int  WR_CYCLES = 1250000,
    localparam int CNT_W     = $clog2(WR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WR_CYCLES - 1);

    // Final busy cycle of the window.
    assign last = busy && (cnt == LAST_IDX);

    // Busy window counter with the end-of-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt == LAST_IDX) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

    // Checker counter: length of the current busy run.
    logic [CNT_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R4: busy lasts exactly WR_CYCLES cycles.
    a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == CNT_W'(WR_CYCLES)));

    // R4: done appears only in the first cycle after busy falls.
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R4: done is a single-cycle pulse.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pws_commit_scan.sv
// Commit scanner: during the busy window, slot k (k < PAGE_BYTES) is given to
// page offset k. A request is raised only when that offset holds received data.
// Assumes WR_CYCLES > PAGE_BYTES, so every slot falls inside the window.
module pws_commit_scan #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int CNT_W      = 21,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFS_W
) (
    input  logic                         busy,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [PAGE_W-1:0]            page,
    input  logic [PAGE_BYTES-1:0]        valid,
    input  logic [PAGE_BYTES*DATA_W-1:0] data_flat,
    input  logic                         clk,
    input  logic                         rst_n,
    output logic                         arr_we,
    output logic [ADDR_W-1:0]            arr_addr,
    output logic [DATA_W-1:0]            arr_wdata
);

    logic             in_window;
    logic [OFS_W-1:0] idx;

    // Slot decode: the low counter bits name the offset being offered.
    always_comb begin
        in_window = busy && (cnt < CNT_W'(PAGE_BYTES));
        idx       = cnt[OFS_W-1:0];
    end

    // Request generation and data selection for the current slot.
    always_comb begin
        arr_we    = in_window && valid[idx];
        arr_addr  = {page, idx};
        arr_wdata = data_flat[idx*DATA_W +: DATA_W];
    end

    // R5: array writes happen only while the cycle is running.
    a_r5_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

endmodule

// File: rtl/page_write_sequencer.sv
// Page write sequencer top: tracks the write transaction, feeds the page
// latch, starts the cycle timer at a qualifying stop and routes the commit
// scanner to the array port.
// Assumes single-cycle strobes from the protocol engine. Within a cycle, stop
// takes priority over start, start over address, and address over data.
module page_write_sequencer #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_stb,
    input  logic              start_stb,
    input  logic              wr_inhibit,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic              done
);
    import pws_pkg::*;

    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);

    phase_t                         phase, phase_nx;
    logic                           lat_clear, lat_load, lat_wr;
    logic [PAGE_W-1:0]              lat_page;
    logic [PAGE_BYTES-1:0]          lat_valid;
    logic [PAGE_BYTES*DATA_W-1:0]   lat_data;
    logic                           lat_any;
    logic                           tmr_start, tmr_last;
    logic [CNT_W-1:0]               tmr_cnt;

    // Phase decode and latch/timer controls for this cycle.
    always_comb begin
        phase_nx  = phase;
        lat_clear = 1'b0;
        lat_load  = 1'b0;
        lat_wr    = 1'b0;
        tmr_start = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (wr_addr_stb && !stop_stb && !start_stb) begin
                    lat_load = 1'b1;
                    phase_nx = PH_COLLECT;
                end
            end
            PH_COLLECT: begin
                if (stop_stb) begin
                    if (lat_any) begin
                        tmr_start = 1'b1;
                        phase_nx  = PH_COMMIT;
                    end else begin
                        lat_clear = 1'b1;
                        phase_nx  = PH_IDLE;
                    end
                end else if (start_stb) begin
                    lat_clear = 1'b1;
                    phase_nx  = PH_IDLE;
                end else if (wr_addr_stb) begin
                    lat_load = 1'b1;
                end else if (byte_stb && wr_inhibit) begin
                    lat_clear = 1'b1;
                    phase_nx  = PH_BLOCKED;
                end else if (byte_stb) begin
                    lat_wr = 1'b1;
                end
            end
            PH_BLOCKED: begin
                if (stop_stb || start_stb) begin
                    lat_clear = 1'b1;
                    phase_nx  = PH_IDLE;
                end
            end
            PH_COMMIT: begin
                if (tmr_last) begin
                    lat_clear = 1'b1;
                    phase_nx  = PH_IDLE;
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    pws_page_latch #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (lat_clear),
        .load      (lat_load),
        .load_addr (wr_addr),
        .wr        (lat_wr),
        .wdata     (byte_data),
        .page      (lat_page),
        .valid     (lat_valid),
        .data_flat (lat_data),
        .any_valid (lat_any)
    );

    pws_cycle_timer #(
        .WR_CYCLES (WR_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy),
        .cnt   (tmr_cnt),
        .last  (tmr_last),
        .done  (done)
    );

    pws_commit_scan #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES),
        .CNT_W      (CNT_W)
    ) u_scan (
        .busy      (busy),
        .cnt       (tmr_cnt),
        .page      (lat_page),
        .valid     (lat_valid),
        .data_flat (lat_data),
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata)
    );

    // R1: outputs are quiet in the cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !arr_we));

    // R4: a qualifying stop raises busy on the next clock.
    a_r4_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COLLECT && stop_stb && lat_any) |=> busy);

    // R6: array writes happen only in the commit phase.
    a_r6_write_only_commit: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (phase == PH_COMMIT));

    // R7: a blocked transaction holds no data.
    a_r7_blocked_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BLOCKED) |-> !lat_any);

    // R8: a repeated start empties the latch.
    a_r8_restart_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COLLECT && start_stb && !stop_stb) |=> !lat_any);

    // R9: the latch is frozen while the cycle runs.
    a_r9_frozen_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_last) |=> $stable(lat_valid));

    // R10: the latch is empty once the cycle is done.
    a_r10_cleared_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lat_any);

endmodule

// File: tb/page_write_sequencer_bench.sv
// Scoreboard bench: driver tasks keep a reference page model and push expected
// array writes into a queue. A monitor pops and compares them as writes appear.
module page_write_sequencer_bench;

    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int PB     = 16;
    localparam int WRC    = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_addr_stb = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              byte_stb = 1'b0;
    logic [DATA_W-1:0] byte_data = '0;
    logic              stop_stb = 1'b0;
    logic              start_stb = 1'b0;
    logic              wr_inhibit = 1'b0;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_wdata;
    logic              busy;
    logic              done;

    page_write_sequencer #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PAGE_BYTES (PB), .WR_CYCLES (WRC)
    ) u_page_write_sequencer (
        .clk (clk), .rst_n (rst_n), .wr_addr_stb (wr_addr_stb), .wr_addr (wr_addr),
        .byte_stb (byte_stb), .byte_data (byte_data), .stop_stb (stop_stb),
        .start_stb (start_stb), .wr_inhibit (wr_inhibit), .arr_we (arr_we),
        .arr_addr (arr_addr), .arr_wdata (arr_wdata), .busy (busy), .done (done)
    );

    always #2 clk = ~clk;  // 250 MHz

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model state.
    logic [DATA_W-1:0]       m_data [PB];
    logic [PB-1:0]           m_valid = '0;
    logic [ADDR_W-5:0]       m_page = '0;
    logic [3:0]              m_ptr = '0;
    bit m_active = 0, m_blocked = 0, m_busy = 0;
    int exp_cycles = 0, cycles_seen = 0;
    logic [ADDR_W+DATA_W-1:0] exp_q[$];

    // Monitor: compares writes, their slot, the busy length and the done pulse.
    int  bidx = 0;
    bit  prev_busy = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bidx = 0;
            prev_busy = 0;
        end else begin
            if (arr_we) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected array write", int'(arr_addr), 0);
                end else begin
                    logic [ADDR_W+DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(arr_addr == e[ADDR_W+DATA_W-1:DATA_W], "R5 write address",
                        int'(arr_addr), int'(e[ADDR_W+DATA_W-1:DATA_W]));
                    chk(arr_wdata == e[DATA_W-1:0], "R3/R5 write data",
                        int'(arr_wdata), int'(e[DATA_W-1:0]));
                    chk(int'(arr_addr[3:0]) == bidx, "R5 write slot",
                        int'(arr_addr[3:0]), bidx);
                end
            end
            if (busy) bidx++;
            if (!busy && prev_busy) begin
                chk(bidx == WRC, "R4 busy length", bidx, WRC);
                chk(done == 1'b1, "R4 done after busy", int'(done), 1);
                cycles_seen++;
                bidx = 0;
            end else if (done) begin
                chk(0, "R4 stray done", 1, 0);
            end
            prev_busy = busy;
        end
    end

    task automatic do_addr(input logic [ADDR_W-1:0] a);
        @(negedge clk); wr_addr_stb = 1'b1; wr_addr = a;
        @(negedge clk); wr_addr_stb = 1'b0;
        if (!m_busy && !m_blocked) begin
            m_page = a[ADDR_W-1:4]; m_ptr = a[3:0]; m_valid = '0; m_active = 1;
        end
    endtask

    task automatic do_byte(input logic [DATA_W-1:0] d, input bit inh);
        @(negedge clk); byte_stb = 1'b1; byte_data = d; wr_inhibit = inh;
        @(negedge clk); byte_stb = 1'b0; wr_inhibit = 1'b0;
        if (!m_busy && m_active && !m_blocked) begin
            if (inh) begin
                m_blocked = 1; m_valid = '0;
            end else begin
                m_data[m_ptr] = d; m_valid[m_ptr] = 1'b1; m_ptr = m_ptr + 1'b1;
            end
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_stb = 1'b1;
        @(negedge clk); start_stb = 1'b0;
        if (!m_busy) begin m_active = 0; m_blocked = 0; m_valid = '0; end
    endtask

    task automatic do_stop(input string tag);
        bit commit;
        commit = !m_busy && m_active && !m_blocked && (m_valid != '0);
        @(negedge clk); stop_stb = 1'b1;
        @(negedge clk); stop_stb = 1'b0;
        chk(busy == (commit || m_busy), tag, int'(busy), int'(commit || m_busy));
        if (commit) begin
            for (int k = 0; k < PB; k++)
                if (m_valid[k]) exp_q.push_back({m_page, 4'(k), m_data[k]});
            exp_cycles++;
            m_busy = 1;
        end
        if (!m_busy || commit) begin m_active = 0; m_blocked = 0; m_valid = '0; end
    endtask

    task automatic finish_op(input string tag);
        if (m_busy) begin
            for (int i = 0; i < WRC + 20 && cycles_seen != exp_cycles; i++) @(negedge clk);
            m_busy = 0;
        end else begin
            repeat (WRC + 4) @(negedge clk);
        end
        chk(cycles_seen == exp_cycles, tag, cycles_seen, exp_cycles);
        chk(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
        chk(busy == 1'b0, {tag, " idle"}, int'(busy), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state.
        chk(!busy && !done && !arr_we, "R1 reset quiet", int'({busy, done, arr_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !arr_we, "R1 after reset", int'({busy, done, arr_we}), 0);

        // R2/R4/R5: three bytes from offset 3 of page 0x12.
        do_addr(11'h123);
        do_byte(8'hA1, 0); do_byte(8'hB2, 0); do_byte(8'hC3, 0);
        do_stop("R4 busy after stop");
        finish_op("R2 R5 short page");

        // R6: stop with no data.
        do_addr(11'h040);
        do_stop("R6 no busy on empty stop");
        finish_op("R6 empty stop");

        // R3: twenty bytes from offset 14 wrap and overwrite.
        do_addr(11'h05E);
        for (int i = 0; i < 20; i++) do_byte(8'(8'h30 + i), 0);
        do_stop("R3 busy after wrap");
        finish_op("R3 wrap overwrite");

        // R7: inhibited byte blocks the transaction.
        do_addr(11'h210);
        do_byte(8'h11, 0); do_byte(8'h22, 1); do_byte(8'h33, 0);
        do_stop("R7 no busy when blocked");
        finish_op("R7 blocked");

        // R8: repeated start discards, then a new address writes only new data.
        do_addr(11'h300);
        do_byte(8'h44, 0); do_byte(8'h55, 0);
        do_start();
        do_stop("R8 no busy after restart");
        finish_op("R8 discard");
        do_addr(11'h301);
        do_byte(8'h66, 0); do_byte(8'h77, 0);
        do_start();
        do_addr(11'h30A);
        do_byte(8'h88, 0);
        do_stop("R8 busy after new address");
        finish_op("R8 new data only");

        // R9: strobes during busy are ignored.
        do_addr(11'h7F0);
        do_byte(8'h9C, 0);
        do_stop("R9 busy starts");
        do_addr(11'h100); do_byte(8'hEE, 0); do_start(); do_stop("R9 busy held");
        finish_op("R9 ignore while busy");

        // R10: stored bytes are cleared after the cycle.
        do_stop("R10 no busy after done");
        finish_op("R10 no leftover cycle");
        do_addr(11'h7F5);
        do_byte(8'h5A, 0);
        do_stop("R10 busy for new data");
        finish_op("R10 only new byte written");

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule